// File: doc/BRIEF.md
# Byte/Word ALU with Status Flags

This block is the arithmetic and logic stage of a small 16-bit RISC core. It takes two already-fetched operands, an operation code, a byte/word size select and the current status word, and on a clock edge where the update strobe is high it registers a result and a new status word. Arithmetic covers addition and subtraction, each with or without the incoming carry, plus a compare. Logic covers AND, bit test, bit clear, bit set and XOR.

In byte mode only the low byte of each operand is used. The written result has its upper byte cleared. The negative, zero, carry and overflow flags are then taken at 8-bit width instead of 16. The interrupt-enable bit, the low-power control bits and all spare status bits are copied from the incoming status word unchanged. Instruction decode, operand fetch and register write-back routing belong to the surrounding core.

Top module: `bw_alu`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `res_o` and `sr_o` both become 0x0000.
- R2: Operation codes are ADD=0, ADDC=1, SUB=2, SUBC=3, CMP=4, AND=5, BIT=6, BIC=7, BIS=8, XOR=9. ADD produces A+B and ADDC produces A+B+C, where C is `sr_i` bit 0.
- R3: SUB produces A+~B+1 and SUBC produces A+~B+C. CMP computes the same flags as SUB. A carry of 1 means no borrow occurred.
- R4: CMP and BIT update the flags but leave `res_o` unchanged.
- R5: The logic operations produce the following results: AND gives A&B, BIC gives A&~B, BIS gives A|B, and XOR gives A^B.
- R6: Status bit positions are C=bit 0, Z=bit 1, N=bit 2 and V=bit 8. In byte mode, N is result bit 7, Z tests the low byte, and C is the carry out of bit 7. In word mode the same flags use bit 15, all 16 bits and the carry out of bit 15.
- R7: For the arithmetic operations, V is set exactly when the signed result at the operand size falls outside the representable range.
- R8: For AND, BIT and XOR, C is the inverse of Z. For AND and BIT, V is 0. For XOR, V is set when both operands are negative at the operand size.
- R9: BIC and BIS copy `sr_i` to `sr_o` without changing any flag.
- R10: In byte mode, bits 15:8 of both operands are ignored, and a written result has bits 15:8 equal to zero.
- R11: On every flag update, `sr_o` bits 7:3 and 15:9 equal the corresponding bits of `sr_i`. Bits 7:3 hold the interrupt enable and the low-power controls.
- R12: When `upd_i` is low, or when the operation code is 10 to 15, neither `res_o` nor `sr_o` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_i | input | 1 | Update strobe; the registers load on an edge where it is high |
| op_i | input | 4 | Operation code |
| byte_i | input | 1 | 1 selects byte size, 0 selects word size |
| opa_i | input | 16 | Operand A |
| opb_i | input | 16 | Operand B |
| sr_i | input | 16 | Current status word; supplies the carry-in and the pass-through bits |
| res_o | output | 16 | Registered result |
| sr_o | output | 16 | Registered updated status word |

## Verification
The assertions assume that `op_i`, `byte_i`, the operands and `sr_i` are stable around the rising edge at which `upd_i` is sampled. They also assume that the status word the core feeds back is the one it wants to be used as the carry-in. The bench meets these assumptions by changing every input only on falling edges, one operation per cycle. It supplies `sr_i` explicitly for each vector, sometimes with the control bits set, so that the pass-through checks see nonzero values. The undefined operation codes 10 to 15 are driven only with the strobe high, in a vector whose expected outcome is that nothing changes.

// File: rtl/bw_alu_pkg.sv
// Shared types for the byte/word ALU: operation codes and status bit positions.
// Assumes a 4-bit operation field; codes above OP_XOR are undefined and ignored.
package bw_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBC = 4'd3,
        OP_CMP  = 4'd4,
        OP_AND  = 4'd5,
        OP_BIT  = 4'd6,
        OP_BIC  = 4'd7,
        OP_BIS  = 4'd8,
        OP_XOR  = 4'd9
    } alu_op_e;

    localparam int SR_C = 0;
    localparam int SR_Z = 1;
    localparam int SR_N = 2;
    localparam int SR_V = 8;

    localparam int CTRL_LO = 3;
    localparam int CTRL_HI = 7;

endpackage

// File: rtl/bw_alu_addsub.sv
// Adder/subtractor at byte or word width.
// When sub_i is set, B is inverted at the operand size before the add, so
// cin_i = 1 gives A-B and carry out 1 means no borrow. In byte mode the upper
// half of each operand is ignored and the upper half of the sum is zero.
// Assumes W is even.
module bw_alu_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         byte_i,
    input  logic         sub_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    localparam int H = W / 2;

    logic [W-1:0] a_m;
    logic [W-1:0] b_m;
    logic [W:0]   full;
    logic         sa, sb, sr;

    // Mask operands to the access size and invert B for subtraction.
    always_comb begin
        a_m = byte_i ? {{H{1'b0}}, a_i[H-1:0]} : a_i;
        if (sub_i)
            b_m = byte_i ? {{H{1'b0}}, ~b_i[H-1:0]} : ~b_i;
        else
            b_m = byte_i ? {{H{1'b0}}, b_i[H-1:0]} : b_i;
    end

    // Add with carry in; pick carry out and the sign bits at the access size.
    always_comb begin
        full   = {1'b0, a_m} + {1'b0, b_m} + {{W{1'b0}}, cin_i};
        sum_o  = byte_i ? {{H{1'b0}}, full[H-1:0]} : full[W-1:0];
        cout_o = byte_i ? full[H] : full[W];
        sa     = byte_i ? a_m[H-1]  : a_m[W-1];
        sb     = byte_i ? b_m[H-1]  : b_m[W-1];
        sr     = byte_i ? full[H-1] : full[W-1];
        ovf_o  = (sa == sb) && (sr != sa);
    end

endmodule

// File: rtl/bw_alu_logic.sv
// Bitwise unit: AND, clear (A & ~B), set (A | B) and XOR at byte or word width.
// Also reports whether both operands are negative at the access size; the XOR
// overflow flag uses this. Assumes W is even.
module bw_alu_logic #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         byte_i,
    input  logic [1:0]   sel_i,
    output logic [W-1:0] res_o,
    output logic         both_neg_o
);
    localparam int H = W / 2;

    logic [W-1:0] raw;

    // Select the bitwise function.
    always_comb begin
        unique case (sel_i)
            2'd0:    raw = a_i & b_i;
            2'd1:    raw = a_i & ~b_i;
            2'd2:    raw = a_i | b_i;
            default: raw = a_i ^ b_i;
        endcase
    end

    // Clear the upper half in byte mode and test the operand signs.
    always_comb begin
        res_o      = byte_i ? {{H{1'b0}}, raw[H-1:0]} : raw;
        both_neg_o = byte_i ? (a_i[H-1] & b_i[H-1]) : (a_i[W-1] & b_i[W-1]);
    end

endmodule

// File: rtl/bw_alu.sv
// Byte/word ALU with a registered result and status word.
// Decodes the operation, runs the arithmetic or the logic unit and forms
// N/Z/C/V at the access size. On an edge where upd_i is high it loads the
// result (for operations that write one) and the status word. The status
// word takes its control and spare bits from sr_i. Assumes sr_i carries the
// current status, whose bit 0 is the carry-in.
module bw_alu #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd_i,
    input  logic [3:0]   op_i,
    input  logic         byte_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic [W-1:0] sr_i,
    output logic [W-1:0] res_o,
    output logic [W-1:0] sr_o
);
    import bw_alu_pkg::*;

    localparam int H = W / 2;

    logic         is_arith, is_sub, cin;
    logic         writes, flags_upd, copy_sr;
    logic [1:0]   lsel;
    logic [W-1:0] asum, lres, res_n, sr_n;
    logic         acout, aovf, lneg2;
    logic         f_n, f_z, f_c, f_v;
    logic [W-1:0] res_q, sr_q;

    // Decode the operation into unit controls and update enables.
    always_comb begin
        is_arith  = 1'b0;
        is_sub    = 1'b0;
        cin       = 1'b0;
        writes    = 1'b0;
        flags_upd = 1'b0;
        copy_sr   = 1'b0;
        lsel      = 2'd0;
        case (op_i)
            OP_ADD:  begin is_arith = 1'b1; writes = 1'b1; flags_upd = 1'b1; end
            OP_ADDC: begin is_arith = 1'b1; cin = sr_i[SR_C]; writes = 1'b1; flags_upd = 1'b1; end
            OP_SUB:  begin is_arith = 1'b1; is_sub = 1'b1; cin = 1'b1; writes = 1'b1; flags_upd = 1'b1; end
            OP_SUBC: begin is_arith = 1'b1; is_sub = 1'b1; cin = sr_i[SR_C]; writes = 1'b1; flags_upd = 1'b1; end
            OP_CMP:  begin is_arith = 1'b1; is_sub = 1'b1; cin = 1'b1; flags_upd = 1'b1; end
            OP_AND:  begin lsel = 2'd0; writes = 1'b1; flags_upd = 1'b1; end
            OP_BIT:  begin lsel = 2'd0; flags_upd = 1'b1; end
            OP_BIC:  begin lsel = 2'd1; writes = 1'b1; copy_sr = 1'b1; end
            OP_BIS:  begin lsel = 2'd2; writes = 1'b1; copy_sr = 1'b1; end
            OP_XOR:  begin lsel = 2'd3; writes = 1'b1; flags_upd = 1'b1; end
            default: ;
        endcase
    end

    bw_alu_addsub #(.W(W)) addsub_i (
        .a_i    (opa_i),
        .b_i    (opb_i),
        .byte_i (byte_i),
        .sub_i  (is_sub),
        .cin_i  (cin),
        .sum_o  (asum),
        .cout_o (acout),
        .ovf_o  (aovf)
    );

    bw_alu_logic #(.W(W)) logic_i (
        .a_i        (opa_i),
        .b_i        (opb_i),
        .byte_i     (byte_i),
        .sel_i      (lsel),
        .res_o      (lres),
        .both_neg_o (lneg2)
    );

    // Pick the result and form the flags at the access size.
    always_comb begin
        res_n = is_arith ? asum : lres;
        f_n   = byte_i ? res_n[H-1] : res_n[W-1];
        f_z   = (res_n == '0);
        if (is_arith) begin
            f_c = acout;
            f_v = aovf;
        end else begin
            f_c = ~f_z;
            f_v = (op_i == OP_XOR) ? lneg2 : 1'b0;
        end
    end

    // Merge new flags into the incoming status word.
    always_comb begin
        sr_n       = sr_i;
        sr_n[SR_C] = f_c;
        sr_n[SR_Z] = f_z;
        sr_n[SR_N] = f_n;
        sr_n[SR_V] = f_v;
    end

    // Result and status registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            sr_q  <= '0;
        end else if (upd_i) begin
            if (writes)
                res_q <= res_n;
            if (flags_upd)
                sr_q <= sr_n;
            else if (copy_sr)
                sr_q <= sr_i;
        end
    end

    assign res_o = res_q;
    assign sr_o  = sr_q;

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (res_o == '0) && (sr_o == '0)); // R1
    AST_CMP_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i && (op_i == OP_CMP || op_i == OP_BIT) |=> $stable(res_o)); // R4
    AST_LOGIC_C_NOT_Z: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i && (op_i == OP_AND || op_i == OP_BIT || op_i == OP_XOR) |=> sr_o[SR_C] == !sr_o[SR_Z]); // R8
    AST_SETCLR_SR_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i && (op_i == OP_BIC || op_i == OP_BIS) |=> sr_o == $past(sr_i)); // R9
    AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i && byte_i && (op_i <= OP_SUBC || (op_i >= OP_AND && op_i <= OP_XOR && op_i != OP_BIT))
        |=> res_o[W-1:H] == '0); // R10
    AST_CTRL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i && op_i <= OP_XOR |=> sr_o[CTRL_HI:CTRL_LO] == $past(sr_i[CTRL_HI:CTRL_LO])); // R11
    AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i || op_i > OP_XOR |=> $stable(res_o) && $stable(sr_o)); // R12

endmodule

// File: tb/bw_alu_tb_top.sv
// Scoreboard bench: the driver computes the expected outputs from the
// requirements and queues them; the monitor compares after each capture edge.
module bw_alu_tb_top;
    localparam int W = 16;

    typedef struct {
        string       tag;
        logic [15:0] res;
        logic [15:0] sr;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic        byte_i = 1'b0;
    logic [15:0] opa_i = '0, opb_i = '0, sr_i = '0;
    logic [15:0] res_o, sr_o;

    int   n_chk = 0;
    int   n_bad = 0;
    exp_t sb_q[$];
    logic [15:0] m_res = '0, m_sr = '0;

    always #5 clk = ~clk;

    bw_alu #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .op_i(op_i), .byte_i(byte_i),
        .opa_i(opa_i), .opb_i(opb_i), .sr_i(sr_i), .res_o(res_o), .sr_o(sr_o)
    );

    // Reference model of one operation, written from the requirements.
    task automatic model(input logic [3:0] op, input logic bm, input logic [15:0] a,
                         input logic [15:0] b, input logic [15:0] sri, input logic upd);
        int mask, half, ua, ub, sum, r, sa, sb, s, cin;
        logic n, z, c, v, wr, fl;
        mask = bm ? 255 : 65535;
        half = bm ? 128 : 32768;
        ua = int'(a) & mask;
        ub = int'(b) & mask;
        wr = 1'b0; fl = 1'b0; n = 0; z = 0; c = 0; v = 0; r = 0;
        if (!upd || op > 4'd9) return;
        sa = (ua >= half) ? ua - 2*half : ua;
        sb = (ub >= half) ? ub - 2*half : ub;
        cin = sri[0];
        if (op <= 4'd4) begin
            fl = 1'b1;
            wr = (op != 4'd4);
            if (op <= 4'd1) begin
                if (op == 4'd0) cin = 0;
                sum = ua + ub + cin;
                s = sa + sb + cin;
            end else begin
                if (op != 4'd3) cin = 1;
                sum = ua + ((~ub) & mask) + cin;
                s = sa - sb - (1 - cin);
            end
            r = sum & mask;
            c = (sum > mask);
            v = (s < -half) || (s > half - 1);
        end else begin
            case (op)
                4'd5, 4'd6: r = ua & ub;
                4'd7:       r = ua & (~ub) & mask;
                4'd8:       r = ua | ub;
                default:    r = ua ^ ub;
            endcase
            wr = (op != 4'd6);
            fl = (op != 4'd7 && op != 4'd8);
            c  = (r != 0);
            v  = (op == 4'd9) && (ua >= half) && (ub >= half);
        end
        n = (r >= half);
        z = (r == 0);
        if (wr) m_res = 16'(r);
        if (fl) begin
            m_sr = sri;
            m_sr[0] = c; m_sr[1] = z; m_sr[2] = n; m_sr[8] = v;
        end else if (op == 4'd7 || op == 4'd8) begin
            m_sr = sri;
        end
    endtask

    // Driver: apply one operation on a falling edge and queue the expectation.
    task automatic drive(input string tag, input logic [3:0] op, input logic bm,
                         input logic [15:0] a, input logic [15:0] b,
                         input logic [15:0] sri, input logic upd);
        exp_t e;
        @(negedge clk);
        op_i = op; byte_i = bm; opa_i = a; opb_i = b; sr_i = sri; upd_i = upd;
        model(op, bm, a, b, sri, upd);
        e.tag = tag; e.res = m_res; e.sr = m_sr;
        sb_q.push_back(e);
    endtask

    // Monitor: compare after each capture edge.
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_chk++;
            if (res_o !== e.res || sr_o !== e.sr) begin
                n_bad++;
                $display("FAIL %s: res=%h sr=%h expected res=%h sr=%h",
                         e.tag, res_o, sr_o, e.res, e.sr);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: timeout expected completion");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset wins over a pending update.
        op_i = 4'd0; opa_i = 16'h1234; opb_i = 16'h1111; sr_i = 16'hFFFF; upd_i = 1'b1;
        repeat (3) @(negedge clk);
        n_chk++;
        if (res_o !== 16'h0 || sr_o !== 16'h0) begin
            n_bad++;
            $display("FAIL R1: res=%h sr=%h expected res=0000 sr=0000", res_o, sr_o);
        end
        rst_n = 1'b1;
        drive("R2 R7 add word overflow",      4'd0, 1'b0, 16'h7FFF, 16'h0001, 16'h0000, 1'b1);
        drive("R6 R10 add byte carry zero",   4'd0, 1'b1, 16'h12FF, 16'h3401, 16'h0000, 1'b1);
        drive("R2 addc word carry in",        4'd1, 1'b0, 16'h1234, 16'h0001, 16'h0001, 1'b1);
        drive("R6 add word carry out",        4'd0, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, 1'b1);
        drive("R3 sub equal",                 4'd2, 1'b0, 16'h0005, 16'h0005, 16'h0000, 1'b1);
        drive("R3 sub borrow",                4'd2, 1'b0, 16'h0003, 16'h0005, 16'h0001, 1'b1);
        drive("R3 subc carry clear",          4'd3, 1'b0, 16'h0010, 16'h0001, 16'h0000, 1'b1);
        drive("R7 sub word overflow",         4'd2, 1'b0, 16'h8000, 16'h0001, 16'h0000, 1'b1);
        drive("R7 R6 sub byte overflow",      4'd2, 1'b1, 16'hFF80, 16'hAA01, 16'h0000, 1'b1);
        drive("R4 R11 cmp keeps result",      4'd4, 1'b0, 16'h0007, 16'h0007, 16'hFEF8, 1'b1);
        drive("R5 R8 and word zero",          4'd5, 1'b0, 16'hF0F0, 16'h0F0F, 16'h0000, 1'b1);
        drive("R4 R8 bit byte negative",      4'd6, 1'b1, 16'h0180, 16'hFF80, 16'h0008, 1'b1);
        drive("R5 R8 xor word both negative", 4'd9, 1'b0, 16'h8001, 16'h8000, 16'h0000, 1'b1);
        drive("R5 R9 bic keeps flags",        4'd7, 1'b0, 16'hFFFF, 16'h00F0, 16'h0105, 1'b1);
        drive("R5 R9 R10 bis byte",           4'd8, 1'b1, 16'hAB10, 16'h0001, 16'h00FA, 1'b1);
        drive("R12 no strobe holds",          4'd0, 1'b0, 16'h1111, 16'h2222, 16'hFFFF, 1'b0);
        drive("R12 undefined code holds",     4'd12, 1'b0, 16'h1111, 16'h2222, 16'hFFFF, 1'b1);
        drive("R8 R6 xor byte both negative", 4'd9, 1'b1, 16'h0080, 16'h0180, 16'h0010, 1'b1);
        drive("R10 add byte upper ignored",   4'd0, 1'b1, 16'hFF05, 16'hEE06, 16'h0000, 1'b1);
        @(negedge clk);
        upd_i = 1'b0;
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule